// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block sits between a 16-bit CPU address bus and a larger external RAM and widens every CPU address into a physical one. The top four CPU address bits pick one of sixteen 12-bit page registers. In mapping mode, that register's contents become the upper physical address lines. The 12-bit page offset always passes straight through, so each 4 KB slice of CPU space can be placed on any 4 KB page of the external memory.

Two single-bit control latches govern the block, and each is written on its own:

- **Access enable (bit 0).** Opens the page registers to the CPU through a small memory window of word-spaced locations. Register n is reached at byte address 0x4000 + 2n.
- **Map enable (bit 1).** Selects between two modes. In pass-through mode the top four CPU bits are zero-extended, so slice n lands on page n. In mapping mode the register contents are substituted.

Software writes page numbers 0 to 255 as single bytes on the even (high) byte lane. In normal use only the slices 0x2000–0x3FFF and 0xA000–0xFFFF are remapped, and the other slices keep their identity page.

Translation is combinational, so the physical address is valid in the same cycle as the CPU address. Register writes and window reads are synchronous to the clock.

Top module: `page_mapper`

## Requirements
- R1: A synchronous reset clears all sixteen page registers to zero, clears the access-enable bit and clears the map-enable bit.
- R2: While map-enable is 0, `phys_addr` equals `cpu_addr` zero-extended to 24 bits, in the same cycle.
- R3: While map-enable is 1, `phys_addr[23:12]` equals the page register indexed by `cpu_addr[15:12]`, in the same cycle.
- R4: `phys_addr[11:0]` always equals `cpu_addr[11:0]`.
- R5: A control write happens when `ctl_sel` and `ctl_we` are both 1 at a clock edge. It loads `ctl_val` into bit `ctl_idx`, where index 0 is access-enable and index 1 is map-enable. Without `ctl_sel`, `ctl_we` changes nothing.
- R6: A write is a window write when `cpu_wr` is 1, access-enable is 1 and `cpu_addr` is even and in the range 0x4000–0x401E. It loads page register `cpu_addr[4:1]` with `{4'b0, cpu_wdata}` at that clock edge.
- R7: A window write attempted while access-enable is 0 leaves every page register unchanged.
- R8: A window read with access-enable 1 puts the indexed register's low 8 bits on `cpu_rdata` one cycle later. In every other cycle after a non-qualifying cycle, `cpu_rdata` is 0.
- R9: Writes to addresses outside 0x4000–0x401E (for example 0x4020 or 0x3FFE) leave every page register unchanged.
- R10: Writing one control bit leaves the other control bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_sel | input | 1 | Control base select |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_idx | input | 1 | Control bit index (0 access, 1 map) |
| ctl_val | input | 1 | Value written to the control bit |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | High byte lane carrying the page number |
| phys_addr | output | 24 | Translated physical address |
| cpu_rdata | output | 8 | Registered window read data |

## Verification
The assertions assume the following about the inputs:

- Control writes and CPU strobes are held for one whole clock and change only between edges.
- `cpu_rd` and `cpu_wr` are never high together.
- Window accesses use even addresses.

The bench drives every input on the falling edge through tasks that raise a strobe for exactly one cycle and never overlap read and write. It samples the combinational address a short delay after each change, and it samples read data on the falling edge after the capturing edge.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int ADDR_W  = 16;
  localparam int IDX_W   = 4;
  localparam int PAGE_W  = 12;
  localparam int BYTE_W  = 8;
  localparam int NCTL    = 2;
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'h4000;

  typedef enum logic [0:0] {
    CTL_ACCESS = 1'b0,
    CTL_MAP    = 1'b1
  } ctl_bit_e;
endpackage

// File: rtl/mapper_ctl.sv
module mapper_ctl
  import mapper_pkg::*;
#(
  parameter int NBITS = NCTL,
  localparam int SEL_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  logic [SEL_W-1:0] idx,
  input  logic             val,
  output logic             acc_en,
  output logic             map_en
);
  logic [NBITS-1:0] bits_q;

  // One latch per control bit, each written individually.
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        bits_q[g] <= 1'b0;
      else if (sel && we && (idx == SEL_W'(g)))
        bits_q[g] <= val;
    end
  end

  assign acc_en = bits_q[CTL_ACCESS];
  assign map_en = bits_q[CTL_MAP];
endmodule

// File: rtl/mapper_window.sv
module mapper_window
  import mapper_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int I_W = IDX_W,
  parameter int P_W = PAGE_W,
  parameter int B_W = BYTE_W,
  parameter logic [A_W-1:0] BASE = WIN_BASE,
  localparam int TAG_LSB = I_W + 1
) (
  input  logic [A_W-1:0] addr,
  input  logic           wr,
  input  logic           rd,
  input  logic           acc_en,
  input  logic [B_W-1:0] wdata,
  output logic           rf_we,
  output logic [I_W-1:0] rf_idx,
  output logic [P_W-1:0] rf_wdata,
  output logic           rd_hit
);
  logic in_win;

  // Word-spaced window: tag above the index, even byte addresses only.
  assign in_win   = (addr[A_W-1:TAG_LSB] == BASE[A_W-1:TAG_LSB]) && !addr[0];
  assign rf_idx   = addr[I_W:1];
  assign rf_we    = acc_en && wr && in_win;
  assign rd_hit   = acc_en && rd && in_win;
  assign rf_wdata = {{(P_W-B_W){1'b0}}, wdata};
endmodule

// File: rtl/mapper_regfile.sv
module mapper_regfile
  import mapper_pkg::*;
#(
  parameter int I_W = IDX_W,
  parameter int P_W = PAGE_W,
  parameter int B_W = BYTE_W,
  localparam int NREG = 1 << I_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [I_W-1:0] widx,
  input  logic [P_W-1:0] wdata,
  input  logic [I_W-1:0] xidx,
  output logic [P_W-1:0] xpage,
  input  logic [I_W-1:0] ridx,
  output logic [B_W-1:0] rbyte
);
  logic [P_W-1:0] pages [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) pages[i] <= '0;
    end else if (we) begin
      pages[widx] <= wdata;
    end
  end

  // Translation port and window read port, both asynchronous.
  assign xpage = pages[xidx];
  assign rbyte = pages[ridx][B_W-1:0];
endmodule

// File: rtl/mapper_xlat.sv
module mapper_xlat
  import mapper_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int I_W = IDX_W,
  parameter int P_W = PAGE_W,
  localparam int OFF_W  = A_W - I_W,
  localparam int PHYS_W = P_W + OFF_W
) (
  input  logic              map_en,
  input  logic [A_W-1:0]    addr,
  input  logic [P_W-1:0]    page,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    if (map_en)
      phys = {page, addr[OFF_W-1:0]};
    else
      phys = {{(P_W-I_W){1'b0}}, addr};
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int I_W = IDX_W,
  parameter int P_W = PAGE_W,
  parameter int B_W = BYTE_W,
  parameter logic [A_W-1:0] BASE = WIN_BASE,
  localparam int OFF_W  = A_W - I_W,
  localparam int PHYS_W = P_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_sel,
  input  logic              ctl_we,
  input  logic              ctl_idx,
  input  logic              ctl_val,
  input  logic [A_W-1:0]    cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [B_W-1:0]    cpu_wdata,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [B_W-1:0]    cpu_rdata
);
  logic           acc_en;
  logic           map_en;
  logic           rf_we;
  logic [I_W-1:0] rf_idx;
  logic [P_W-1:0] rf_wdata;
  logic           rd_hit;
  logic [P_W-1:0] xpage;
  logic [B_W-1:0] rbyte;

  mapper_ctl #(.NBITS(NCTL)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .sel    (ctl_sel),
    .we     (ctl_we),
    .idx    (ctl_idx),
    .val    (ctl_val),
    .acc_en (acc_en),
    .map_en (map_en)
  );

  mapper_window #(.A_W(A_W), .I_W(I_W), .P_W(P_W), .B_W(B_W), .BASE(BASE)) u_win (
    .addr     (cpu_addr),
    .wr       (cpu_wr),
    .rd       (cpu_rd),
    .acc_en   (acc_en),
    .wdata    (cpu_wdata),
    .rf_we    (rf_we),
    .rf_idx   (rf_idx),
    .rf_wdata (rf_wdata),
    .rd_hit   (rd_hit)
  );

  mapper_regfile #(.I_W(I_W), .P_W(P_W), .B_W(B_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .widx  (rf_idx),
    .wdata (rf_wdata),
    .xidx  (cpu_addr[A_W-1:OFF_W]),
    .xpage (xpage),
    .ridx  (rf_idx),
    .rbyte (rbyte)
  );

  mapper_xlat #(.A_W(A_W), .I_W(I_W), .P_W(P_W)) u_xlat (
    .map_en (map_en),
    .addr   (cpu_addr),
    .page   (xpage),
    .phys   (phys_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)
      cpu_rdata <= '0;
    else
      cpu_rdata <= rd_hit ? rbyte : '0;
  end
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int A_W = 16,
  parameter int I_W = 4,
  parameter int P_W = 12,
  parameter int B_W = 8,
  parameter logic [A_W-1:0] BASE = 16'h4000,
  localparam int OFF_W   = A_W - I_W,
  localparam int PHYS_W  = P_W + OFF_W,
  localparam int TAG_LSB = I_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_sel,
  input logic              ctl_we,
  input logic              ctl_idx,
  input logic              ctl_val,
  input logic [A_W-1:0]    cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [B_W-1:0]    cpu_rdata,
  input logic              acc_en,
  input logic              map_en,
  input logic              rf_we
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  logic in_win;
  assign in_win = (cpu_addr[A_W-1:TAG_LSB] == BASE[A_W-1:TAG_LSB]) && !cpu_addr[0];

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> (!acc_en && !map_en));

  assert_passthru_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !map_en |-> (phys_addr == {{(P_W-I_W){1'b0}}, cpu_addr}));

  assert_offset_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  assert_ctl_load_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (ctl_sel && ctl_we && ctl_idx) |=> (map_en == $past(ctl_val)));

  assert_ctl_hold_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    !(ctl_sel && ctl_we) |=> ($stable(map_en) && $stable(acc_en)));

  assert_blocked_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    (cpu_wr && !acc_en) |-> !rf_we);

  assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    !(cpu_rd && acc_en && in_win) |=> (cpu_rdata == '0));

  assert_ctl_indep_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    (ctl_sel && ctl_we && !ctl_idx) |=> $stable(map_en));
endmodule

bind page_mapper mapper_checker #(
  .A_W(A_W), .I_W(I_W), .P_W(P_W), .B_W(B_W), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_sel   (ctl_sel),
  .ctl_we    (ctl_we),
  .ctl_idx   (ctl_idx),
  .ctl_val   (ctl_val),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .phys_addr (phys_addr),
  .cpu_rdata (cpu_rdata),
  .acc_en    (acc_en),
  .map_en    (map_en),
  .rf_we     (rf_we)
);

// File: tb/tb_page_mapper.sv
module tb_page_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {cpu address, expected physical address in mapping mode}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h2000, 24'h010000},
    {16'h3FFE, 24'h011FFE},
    {16'hA123, 24'h080123},
    {16'hBFFF, 24'h081FFF},
    {16'hC800, 24'h0FE800},
    {16'hD001, 24'h0FF001},
    {16'hE555, 24'h000555},
    {16'hF00F, 24'h04200F},
    {16'h1234, 24'h000234},
    {16'h0000, 24'h000000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_sel = 1'b0, ctl_we = 1'b0, ctl_idx = 1'b0, ctl_val = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [23:0] phys_addr;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_mapper dut (
    .clk(clk), .rst(rst), .ctl_sel(ctl_sel), .ctl_we(ctl_we), .ctl_idx(ctl_idx),
    .ctl_val(ctl_val), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .phys_addr(phys_addr), .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic idx, input logic val, input logic sel);
    @(negedge clk);
    ctl_sel = sel; ctl_we = 1'b1; ctl_idx = idx; ctl_val = val;
    @(negedge clk);
    ctl_sel = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic win_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic win_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic xlat(input string req, input logic [15:0] a, input logic [23:0] exp);
    cpu_addr = a;
    #1;
    check(req, {8'h0, phys_addr}, {8'h0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    do_reset();

    // R1 / R2: pass-through after reset
    xlat("R1 passthru after reset", 16'hA123, 24'h00A123);
    // R8: read with access disabled returns zero
    win_read(16'h4014, rd);
    check("R8 read without access", {24'h0, rd}, 32'h0);

    // R5: write without base select changes nothing
    ctl_write(1'b1, 1'b1, 1'b0);
    xlat("R5 no select ignored", 16'hB456, 24'h00B456);
    // R5 / R1: map on with cleared registers
    ctl_write(1'b1, 1'b1, 1'b1);
    xlat("R1 regs cleared, map on", 16'hB456, 24'h000456);

    // R7: blocked window write, then open access and read back
    win_write(16'h4014, 8'h55);
    ctl_write(1'b0, 1'b1, 1'b1);
    xlat("R10 map bit kept after access set", 16'hB456, 24'h000456);
    win_read(16'h4014, rd);
    check("R7 blocked write left reg", {24'h0, rd}, 32'h0);

    // R6: program pages
    win_write(16'h4004, 8'h10);
    win_write(16'h4006, 8'h11);
    win_write(16'h4014, 8'h80);
    win_write(16'h4016, 8'h81);
    win_write(16'h4018, 8'hFE);
    win_write(16'h401A, 8'hFF);
    win_write(16'h401C, 8'h00);
    win_write(16'h401E, 8'h42);
    win_read(16'h4018, rd);
    check("R6 R8 readback slice C", {24'h0, rd}, 32'h0000_00FE);
    win_read(16'h401E, rd);
    check("R6 R8 readback slice F", {24'h0, rd}, 32'h0000_0042);

    // R3 / R4: table walk in mapping mode
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      xlat("R3 R4 mapped table", VEC[i][39:24], VEC[i][23:0]);
    end

    // R9: writes just outside the window
    win_write(16'h4020, 8'h99);
    win_write(16'h3FFE, 8'h77);
    @(negedge clk);
    xlat("R9 reg0 untouched", 16'h0ABC, 24'h000ABC);
    xlat("R9 regF untouched", 16'hF00F, 24'h04200F);

    // R8 / R10: close access; mapping stays on
    ctl_write(1'b0, 1'b0, 1'b1);
    win_read(16'h401E, rd);
    check("R8 read after access closed", {24'h0, rd}, 32'h0);
    xlat("R10 map kept after access cleared", 16'hF00F, 24'h04200F);

    // R2: back to pass-through
    ctl_write(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < NVEC; i++) begin
      xlat("R2 passthru table", VEC[i][39:24], {8'h00, VEC[i][39:24]});
    end

    // R1: reset in mid-run clears registers and control bits
    do_reset();
    xlat("R1 map off after reset", 16'hF00F, 24'h00F00F);
    win_read(16'h4014, rd);
    check("R1 access off after reset", {24'h0, rd}, 32'h0);
    ctl_write(1'b0, 1'b1, 1'b1);
    ctl_write(1'b1, 1'b1, 1'b1);
    xlat("R1 regs cleared after reset", 16'hA123, 24'h000123);
    win_read(16'h4014, rd);
    check("R1 readback zero after reset", {24'h0, rd}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule